// File: doc/BRIEF.md
# Watermark Flow Control Trigger

This block decides, from how full a receive FIFO has become, when the pause-frame generator should send a flow-control frame on its own. It watches the number of vacant FIFO entries and a strobe that marks a new packet entering the FIFO. When a packet arrives while the vacancy has dropped below a programmable "congest" threshold, it issues a one-cycle request carrying the programmed pause time. It then marks flow control as active.

Flow control stays active until the vacancy climbs back to a second, "relief" threshold. At that point a single request with a zero pause time is issued, so that the link partner may resume at once. Only one request can be outstanding toward the generator at a time, and a done strobe from the generator frees the slot. The whole mechanism works only while the enable input is set and the link runs full duplex. Leaving that condition drops everything.

Top module: `wm_flow_trigger`

## Requirements
- R1: Automatic flow control is allowed only while `fc_en_i` and `full_duplex_i` are both 1. While not allowed, no request is issued. One cycle after allowance is lost, `fc_active_o` is 0 and any outstanding request is forgotten.
- R2: When `pkt_arrive_i` is 1 and `vacant_i` is strictly less than `congest_thr_i` in a cycle with a free slot, `pause_req_o` is 1 in the following cycle. In that cycle `pause_val_o` equals `pause_time_i` as sampled in the triggering cycle.
- R3: A vacancy equal to or above `congest_thr_i` causes no request, even with an arrival. A low vacancy without `pkt_arrive_i` also causes no request.
- R4: `fc_active_o` becomes 1 in the cycle the first pause request appears, and stays 1 while vacancy remains below `relief_thr_i`.
- R5: While active with a free slot, a vacancy at or above `relief_thr_i` (no arrival trigger) causes one request with `pause_val_o` = 0. `fc_active_o` drops to 0 in that same cycle.
- R6: After a request, no further request is issued until `gen_done_i` has been seen. A done in cycle d allows a new request to appear in cycle d+2 at the earliest. Triggers that occur while a request is outstanding are dropped and not remembered.
- R7: `pause_req_o` is never 1 in two consecutive cycles.
- R8: If an arrival trigger and the relief condition hold in the same cycle, the pause request (non-zero value, `fc_active_o` stays 1) takes priority.
- R9: After allowance is lost and regained, a new trigger issues a request without waiting for `gen_done_i`.
- R10: After reset, `pause_req_o`, `pause_val_o` and `fc_active_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fc_en_i | input | 1 | Automatic flow control enable |
| full_duplex_i | input | 1 | Link is in full-duplex mode |
| vacant_i | input | CNT_W | Number of vacant receive FIFO entries |
| pkt_arrive_i | input | 1 | A new packet enters the receive FIFO this cycle |
| congest_thr_i | input | CNT_W | Vacancy below this, on arrival, triggers a pause |
| relief_thr_i | input | CNT_W | Vacancy at or above this ends the congested state |
| pause_time_i | input | PAUSE_W | Pause time used in triggered requests |
| gen_done_i | input | 1 | Generator finished the outstanding request |
| pause_req_o | output | 1 | One-cycle request to the pause generator |
| pause_val_o | output | PAUSE_W | Pause time for the request, valid with `pause_req_o` |
| fc_active_o | output | 1 | Flow control is active |

## Verification
The assertions assume `gen_done_i` only answers a request that was actually issued. A done with nothing outstanding has no effect, and none of the properties depends on it. They also assume the thresholds stay steady while a request is being decided. The directed phases change `congest_thr_i` and `relief_thr_i` only while no request is pending. The random phase draws vacancy, arrivals and done pulses freely, with the thresholds held fixed. The behavioural model tracks any done strobe the way the block must, so stray dones also exercise the ignore path.

// File: rtl/wm_flow_pkg.sv
package wm_flow_pkg;
  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_PAUSE  = 2'd1,
    REQ_RESUME = 2'd2
  } req_kind_e;
endpackage

// File: rtl/wm_compare.sv
module wm_compare #(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] vacant_i,
  input  logic             pkt_arrive_i,
  input  logic [CNT_W-1:0] congest_thr_i,
  input  logic [CNT_W-1:0] relief_thr_i,
  output logic             congest_hit_o,
  output logic             relief_o
);
  assign congest_hit_o = pkt_arrive_i && (vacant_i < congest_thr_i);
  assign relief_o      = (vacant_i >= relief_thr_i);
endmodule

// File: rtl/wm_hyst.sv
module wm_hyst
  import wm_flow_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      allow_i,
  input  logic      congest_hit_i,
  input  logic      relief_i,
  input  logic      slot_free_i,
  output req_kind_e kind_o,
  output logic      active_o
);
  logic active_q;

  // arrival trigger wins over relief
  always_comb begin
    kind_o = REQ_NONE;
    if (allow_i && slot_free_i) begin
      if (congest_hit_i)              kind_o = REQ_PAUSE;
      else if (active_q && relief_i)  kind_o = REQ_RESUME;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   active_q <= 1'b0;
    else if (!allow_i)             active_q <= 1'b0;
    else if (kind_o == REQ_PAUSE)  active_q <= 1'b1;
    else if (kind_o == REQ_RESUME) active_q <= 1'b0;
  end

  assign active_o = active_q;

  assert_pause_sets_active_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (allow_i && slot_free_i && congest_hit_i) |=> active_o);
  assert_trigger_priority_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (congest_hit_i && relief_i) |-> (kind_o != REQ_RESUME));
endmodule

// File: rtl/wm_req_tracker.sv
module wm_req_tracker
  import wm_flow_pkg::*;
#(
  parameter int PAUSE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               allow_i,
  input  req_kind_e          kind_i,
  input  logic [PAUSE_W-1:0] pause_time_i,
  input  logic               gen_done_i,
  output logic               slot_free_o,
  output logic               req_o,
  output logic [PAUSE_W-1:0] val_o
);
  logic               busy_q;
  logic               req_q;
  logic [PAUSE_W-1:0] val_q;
  logic               fire;

  assign fire = (kind_i != REQ_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      val_q  <= '0;
    end else if (!allow_i) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= fire;
      if (fire) begin
        busy_q <= 1'b1;
        val_q  <= (kind_i == REQ_PAUSE) ? pause_time_i : '0;
      end else if (gen_done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign slot_free_o = !busy_q;
  assign req_o       = req_q;
  assign val_o       = val_q;

  assert_single_outstanding_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !gen_done_i) |=> !req_o);
  assert_req_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  assert_drop_on_disallow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !allow_i |=> (!req_o && slot_free_o));
endmodule

// File: rtl/wm_flow_trigger.sv
module wm_flow_trigger
  import wm_flow_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int PAUSE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fc_en_i,
  input  logic               full_duplex_i,
  input  logic [CNT_W-1:0]   vacant_i,
  input  logic               pkt_arrive_i,
  input  logic [CNT_W-1:0]   congest_thr_i,
  input  logic [CNT_W-1:0]   relief_thr_i,
  input  logic [PAUSE_W-1:0] pause_time_i,
  input  logic               gen_done_i,
  output logic               pause_req_o,
  output logic [PAUSE_W-1:0] pause_val_o,
  output logic               fc_active_o
);
  logic      allow;
  logic      congest_hit;
  logic      relief;
  logic      slot_free;
  req_kind_e kind;

  assign allow = fc_en_i && full_duplex_i;

  wm_compare #(.CNT_W(CNT_W)) u_cmp (
    .vacant_i      (vacant_i),
    .pkt_arrive_i  (pkt_arrive_i),
    .congest_thr_i (congest_thr_i),
    .relief_thr_i  (relief_thr_i),
    .congest_hit_o (congest_hit),
    .relief_o      (relief)
  );

  wm_hyst u_hyst (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .allow_i       (allow),
    .congest_hit_i (congest_hit),
    .relief_i      (relief),
    .slot_free_i   (slot_free),
    .kind_o        (kind),
    .active_o      (fc_active_o)
  );

  wm_req_tracker #(.PAUSE_W(PAUSE_W)) u_trk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .allow_i      (allow),
    .kind_i       (kind),
    .pause_time_i (pause_time_i),
    .gen_done_i   (gen_done_i),
    .slot_free_o  (slot_free),
    .req_o        (pause_req_o),
    .val_o        (pause_val_o)
  );

  assert_resume_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == REQ_RESUME) |=> (pause_req_o && pause_val_o == '0 && !fc_active_o));
  assert_pause_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == REQ_PAUSE) |=> (pause_req_o && pause_val_o == $past(pause_time_i)));
  assert_inactive_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !allow |=> !fc_active_o);
endmodule

// File: tb/wm_flow_trigger_tb.sv
`timescale 1ns/1ps
module wm_flow_trigger_tb;
  localparam int CNT_W   = 6;
  localparam int PAUSE_W = 16;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               fc_en_i = 1'b0, full_duplex_i = 1'b0;
  logic [CNT_W-1:0]   vacant_i = '0, congest_thr_i = 6'd8, relief_thr_i = 6'd24;
  logic               pkt_arrive_i = 1'b0, gen_done_i = 1'b0;
  logic [PAUSE_W-1:0] pause_time_i = 16'h1234;
  logic               pause_req_o, fc_active_o;
  logic [PAUSE_W-1:0] pause_val_o;

  int checks = 0, fails = 0;
  string cur_tag = "R10";
  bit finished = 0;

  always #2.5 clk = ~clk;

  wm_flow_trigger #(.CNT_W(CNT_W), .PAUSE_W(PAUSE_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fc_en_i(fc_en_i), .full_duplex_i(full_duplex_i),
    .vacant_i(vacant_i), .pkt_arrive_i(pkt_arrive_i), .congest_thr_i(congest_thr_i),
    .relief_thr_i(relief_thr_i), .pause_time_i(pause_time_i), .gen_done_i(gen_done_i),
    .pause_req_o(pause_req_o), .pause_val_o(pause_val_o), .fc_active_o(fc_active_o)
  );

  // behavioural reference
  bit m_req, m_act, m_out;
  int m_val;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_req = 0; m_act = 0; m_out = 0; m_val = 0;
    end else begin
      bit allow, hit, rel;
      allow = fc_en_i && full_duplex_i;
      hit   = pkt_arrive_i && (int'(vacant_i) < int'(congest_thr_i));
      rel   = int'(vacant_i) >= int'(relief_thr_i);
      m_req = 0;
      if (!allow) begin
        m_act = 0; m_out = 0;
      end else if (!m_out && hit) begin
        m_req = 1; m_val = pause_time_i; m_act = 1; m_out = 1;
      end else if (!m_out && m_act && rel) begin
        m_req = 1; m_val = 0; m_act = 0; m_out = 1;
      end else if (m_out && gen_done_i) begin
        m_out = 0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    chk(cur_tag, pause_req_o, m_req, "req");
    chk(cur_tag, pause_val_o, m_val, "val");
    chk(cur_tag, fc_active_o, m_act, "active");
  end

  task automatic cyc(bit arr, int vac, bit done = 0);
    pkt_arrive_i = arr; vacant_i = vac[CNT_W-1:0]; gen_done_i = done;
    @(negedge clk);
    pkt_arrive_i = 0; gen_done_i = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", pause_req_o, 0, "reset req");
    chk("R10", pause_val_o, 0, "reset val");
    chk("R10", fc_active_o, 0, "reset active");
    rst_ni = 1;
    @(negedge clk);

    cur_tag = "R1";
    cyc(1, 2);                 chk("R1", pause_req_o, 0, "disabled req");
    fc_en_i = 1;
    cyc(1, 2);                 chk("R1", pause_req_o, 0, "half duplex req");
    full_duplex_i = 1;

    cur_tag = "R2";
    cyc(1, 7);                 chk("R2", pause_req_o, 1, "trigger req");
                               chk("R2", pause_val_o, 16'h1234, "trigger val");
                               chk("R4", fc_active_o, 1, "active on");
    cur_tag = "R7";
    cyc(0, 7);                 chk("R7", pause_req_o, 0, "pulse");
    cur_tag = "R6";
    cyc(1, 3);                 chk("R6", pause_req_o, 0, "blocked while outstanding");
    cyc(0, 3, 1);              chk("R6", pause_req_o, 0, "done cycle");
    cyc(1, 3);                 chk("R6", pause_req_o, 1, "after done");
    cyc(0, 3, 1);

    cur_tag = "R3";
    cyc(1, 8);                 chk("R3", pause_req_o, 0, "vac equals threshold");
    cyc(0, 2);                 chk("R3", pause_req_o, 0, "no arrival");
    cur_tag = "R4";
    cyc(0, 23);                chk("R4", fc_active_o, 1, "held below relief");
    cur_tag = "R5";
    cyc(0, 24);                chk("R5", pause_req_o, 1, "resume req");
                               chk("R5", pause_val_o, 0, "resume val");
                               chk("R5", fc_active_o, 0, "active off");
    cyc(0, 30, 1);             chk("R5", pause_req_o, 0, "single resume");

    cur_tag = "R8";
    congest_thr_i = 20; relief_thr_i = 10;
    cyc(1, 5);                 chk("R8", fc_active_o, 1, "set active");
    cyc(0, 5, 1);
    cyc(1, 15);                chk("R8", pause_req_o, 1, "priority req");
                               chk("R8", pause_val_o, 16'h1234, "priority val");
                               chk("R8", fc_active_o, 1, "still active");
    cyc(0, 5, 1);
    congest_thr_i = 8; relief_thr_i = 24;

    cur_tag = "R9";
    pause_time_i = 16'h00ff;
    cyc(1, 2);                 chk("R9", pause_req_o, 1, "req before drop");
    fc_en_i = 0;
    cyc(0, 2);                 chk("R1", fc_active_o, 0, "drop clears active");
    fc_en_i = 1;
    cyc(1, 2);                 chk("R9", pause_req_o, 1, "no done needed");
                               chk("R9", pause_val_o, 16'h00ff, "new value");
    full_duplex_i = 0;
    cyc(0, 2);                 chk("R1", fc_active_o, 0, "duplex drop");
    full_duplex_i = 1;

    cur_tag = "R2/R5/R6";
    for (int i = 0; i < 3000; i++) begin
      pause_time_i = 16'($urandom);
      if (($urandom % 97) == 0) fc_en_i = ~fc_en_i;
      cyc(($urandom % 3) == 0, $urandom % 40, ($urandom % 4) == 0);
    end
    fc_en_i = 1;
    repeat (2) @(negedge clk);

    finished = 1;
    summary();
    $finish;
  end
endmodule